// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Integer Multiplier

This block multiplies two 32-bit integers and returns the full 64-bit product. A single select input picks whether both operands are read as two's complement or as plain unsigned values. One new operation can be accepted on every clock, and results come out in the order they were issued.

The datapath has four register stages. The first stage extends the operands by one bit, recodes the multiplier into radix-4 digits and builds one partial-product row per digit. The second and third stages each run two levels of a 4:2 compressor tree, which leaves a redundant sum/carry pair. The fourth stage resolves that pair with a parallel-prefix adder. A valid flag travels with the data, and the product is meaningful only while `valid_o` is high. The block has no stall or backpressure path.

Top module: `booth_mul_pipe`

## Requirements
- R1: With `signed_i`=1, the block reads `a_i` and `b_i` as 32-bit two's complement values, and `product_o` equals their exact 64-bit two's complement product.
- R2: With `signed_i`=0, the block reads both operands as unsigned values in the range 0 to 2^32-1, and `product_o` equals their exact 64-bit unsigned product.
- R3: If `valid_i` is high at rising edge k, the result for those operands is on `product_o` and `valid_o` is high from just after rising edge k+3 until rising edge k+4. Edge k+3 is the fourth edge, counting the edge that samples the operands.
- R4: `valid_o` is a copy of `valid_i` delayed by four rising edges. When `valid_i` is low, the operands at that edge never cause `valid_o` to go high.
- R5: Operations issued on consecutive cycles, or with idle gaps between them, each produce their own correct result, in issue order, with no interference between neighbours.
- R6: While `rst_ni` is low, `valid_o` and `product_o` are 0, and they clear at once without waiting for a clock edge. Operations in flight when reset is asserted are discarded.
- R7: The most negative operand, 0x80000000, gives the correct product: 0x4000000000000000 when squared in either mode, 0xFFFFFFFF80000000 for times 1 in signed mode, and 0x0000000080000000 for times -1 in signed mode.
- R8: A zero operand gives a zero product in both modes.
- R9: With all-ones operands, the product is 1 in signed mode (-1 times -1) and 0xFFFFFFFE00000001 in unsigned mode.
- R10: In signed mode, two nonzero operands of opposite sign give a product with bit 63 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are present this cycle |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier (Booth-recoded) |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned operands |
| valid_o | output | 1 | `product_o` holds a result |
| product_o | output | 64 | Full-width product |

## Verification
A table of fixed operand pairs is issued back to back. It contains zero, plus and minus one, the most negative value, all-ones, the largest positive value and small mixed-sign pairs. Some of these pairs are run in both modes, so a mistake in the unsigned extension or in the sign handling of a row shows up as a mode-specific mismatch. Random operands in both modes test every Booth digit value at every row position, which a wrong digit decode, an injected +1 at the wrong position or a misplaced sign-prefix constant cannot survive. Further runs interleave idle cycles, single isolated operations and a reset during traffic, which separate a correct four-edge latency and a correct valid path from an off-by-one stage or a flushed result that leaks out.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Booth digits needed for a width-w operand after 1-bit extension
  function automatic int booth_digits(input int w);
    return (w + 2) / 2;
  endfunction

  // Rows left after one 4:2 level (inputs padded to a multiple of 4)
  function automatic int c42_out(input int n);
    return 2 * ((n + 3) / 4);
  endfunction

  // Sum of the sign-prefix corrections: -2^(w+1+2i) for every digit row
  function automatic logic [127:0] sign_fix(input int w);
    logic [127:0] c;
    c = '0;
    for (int i = 0; i < (w + 2) / 2; i++) c = c - (128'd1 << (w + 1 + 2 * i));
    return c;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mul_pkg::*;
#(
  parameter int W = 32,
  localparam int NG = (W + 2) / 2,
  localparam int NR = NG + 1,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          signed_i,
  output logic [PW-1:0] rows_o [NR]
);

  localparam logic [127:0] FIX = sign_fix(W);

  logic [W:0]   xe;
  logic [W:0]   ye;
  logic [W+2:0] yg;
  logic [NG-1:0] neg_bits;
  logic [PW-1:0] fix_row;

  assign xe = {signed_i & a_i[W-1], a_i};
  assign ye = {signed_i & b_i[W-1], b_i};
  assign yg = {ye[W], ye, 1'b0};

  for (genvar g = 0; g < NG; g++) begin : g_dig
    logic [2:0]   t;
    logic         one, two, neg;
    logic [W+1:0] mag, row;

    assign t   = yg[2*g+2 : 2*g];
    assign one = t[0] ^ t[1];
    assign two = (t[2] & ~t[1] & ~t[0]) | (~t[2] & t[1] & t[0]);
    assign neg = t[2] & ~(t[1] & t[0]);
    assign mag = one ? {xe[W], xe} : (two ? {xe, 1'b0} : '0);
    assign row = mag ^ {(W+2){neg}};
    // sign bit inverted; its -2^(W+1) weight lives in fix_row
    assign rows_o[g] = {{(PW-W-2){1'b0}}, ~row[W+1], row[W:0]} << (2 * g);
    assign neg_bits[g] = neg;
  end

  // +1 of each negated row; these sit below the lowest constant bit
  always_comb begin
    fix_row = FIX[PW-1:0];
    for (int g = 0; g < NG; g++) fix_row[2*g] = neg_bits[g];
  end

  assign rows_o[NG] = fix_row;

endmodule

// File: rtl/c42_row.sv
module c42_row #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] carry_o
);

  logic [DW-1:0] s1, cin;
  logic [DW-2:0] co, cy;

  assign s1  = a_i ^ b_i ^ c_i;
  assign co  = (a_i[DW-2:0] & b_i[DW-2:0]) | (a_i[DW-2:0] & c_i[DW-2:0]) |
               (b_i[DW-2:0] & c_i[DW-2:0]);
  assign cin = {co, 1'b0};  // lateral carry: never ripples further
  assign sum_o = s1 ^ d_i ^ cin;
  assign cy  = (s1[DW-2:0] & d_i[DW-2:0]) | (s1[DW-2:0] & cin[DW-2:0]) |
               (d_i[DW-2:0] & cin[DW-2:0]);
  assign carry_o = {cy, 1'b0};

endmodule

// File: rtl/c42_level.sv
module c42_level
  import booth_mul_pkg::*;
#(
  parameter int DW   = 64,
  parameter int N_IN = 18,
  localparam int N_OUT = 2 * ((N_IN + 3) / 4)
) (
  input  logic [DW-1:0] rows_i [N_IN],
  output logic [DW-1:0] rows_o [N_OUT]
);

  for (genvar k = 0; k < N_OUT / 2; k++) begin : g_cell
    logic [DW-1:0] q [4];
    for (genvar m = 0; m < 4; m++) begin : g_pick
      if (4 * k + m < N_IN) begin : g_row
        assign q[m] = rows_i[4*k+m];
      end else begin : g_pad
        assign q[m] = '0;
      end
    end
    c42_row #(.DW(DW)) u_c42 (
      .a_i(q[0]), .b_i(q[1]), .c_i(q[2]), .d_i(q[3]),
      .sum_o(rows_o[2*k]), .carry_o(rows_o[2*k+1])
    );
  end

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int DW = 64,
  localparam int L = $clog2(DW - 1)
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o
);

  logic [DW-1:0] hs;
  logic [DW-2:0] gk [L+1];
  logic [DW-2:0] pk [L];

  assign hs    = a_i ^ b_i;
  assign gk[0] = a_i[DW-2:0] & b_i[DW-2:0];
  assign pk[0] = hs[DW-2:0];

  for (genvar lv = 0; lv < L; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    for (genvar i = 0; i < DW - 1; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign gk[lv+1][i] = gk[lv][i] | (pk[lv][i] & gk[lv][i-D]);
        if (lv + 1 < L) begin : g_p
          assign pk[lv+1][i] = pk[lv][i] & pk[lv][i-D];
        end
      end else begin : g_pass
        assign gk[lv+1][i] = gk[lv][i];
        if (lv + 1 < L) begin : g_p
          assign pk[lv+1][i] = pk[lv][i];
        end
      end
    end
  end

  assign sum_o = hs ^ {gk[L], 1'b0};

endmodule

// File: rtl/booth_mul_pipe.sv
module booth_mul_pipe
  import booth_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           signed_i,
  output logic           valid_o,
  output logic [2*W-1:0] product_o
);

  localparam int PW  = 2 * W;
  localparam int NR  = booth_digits(W) + 1;
  localparam int N2A = c42_out(NR);
  localparam int N2B = c42_out(N2A);
  localparam int N3A = c42_out(N2B);
  localparam int N3B = c42_out(N3A);

  // stage 1: recode and partial products
  logic [PW-1:0] pp_rows [NR];
  logic [PW-1:0] r1_q    [NR];
  logic          v1_q;

  booth_pp_gen #(.W(W)) u_pp (
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .rows_o(pp_rows)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      r1_q <= '{default: '0};
    end else begin
      v1_q <= valid_i;
      r1_q <= pp_rows;
    end
  end

  // stage 2: first two compressor levels
  logic [PW-1:0] ra   [N2A];
  logic [PW-1:0] rb   [N2B];
  logic [PW-1:0] r2_q [N2B];
  logic          v2_q;

  c42_level #(.DW(PW), .N_IN(NR))  u_lv_a (.rows_i(r1_q), .rows_o(ra));
  c42_level #(.DW(PW), .N_IN(N2A)) u_lv_b (.rows_i(ra),   .rows_o(rb));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q <= 1'b0;
      r2_q <= '{default: '0};
    end else begin
      v2_q <= v1_q;
      r2_q <= rb;
    end
  end

  // stage 3: remaining levels down to a sum/carry pair
  logic [PW-1:0] rc [N3A];
  logic [PW-1:0] rd [N3B];
  logic [PW-1:0] s3_q, c3_q;
  logic          v3_q;

  c42_level #(.DW(PW), .N_IN(N2B)) u_lv_c (.rows_i(r2_q), .rows_o(rc));
  c42_level #(.DW(PW), .N_IN(N3A)) u_lv_d (.rows_i(rc),   .rows_o(rd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3_q <= 1'b0;
      s3_q <= '0;
      c3_q <= '0;
    end else begin
      v3_q <= v2_q;
      s3_q <= rd[0];
      c3_q <= rd[1];
    end
  end

  // stage 4: carry-propagate resolve
  logic [PW-1:0] sum4;

  prefix_adder #(.DW(PW)) u_cpa (.a_i(s3_q), .b_i(c3_q), .sum_o(sum4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      product_o <= '0;
    end else begin
      valid_o   <= v3_q;
      product_o <= sum4;
    end
  end

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           signed_i,
  input logic           valid_o,
  input logic [2*W-1:0] product_o
);

  logic [2:0] edges_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             edges_q <= '0;
    else if (edges_q != 3'd4) edges_q <= edges_q + 3'd1;
  end
  assign warm = (edges_q == 3'd4);

  function automatic logic [2*W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic s);
    logic [2*W-1:0] ae, be;
    ae = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    be = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ae * be;
  endfunction

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (warm ? $past(valid_i, 4) : 1'b0)) else $error("valid latency"); // R4

  AST_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o) |-> product_o == model($past(a_i, 4), $past(b_i, 4), $past(signed_i, 4)))
    else $error("product mismatch"); // R1

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && ($past(a_i, 4) == '0 || $past(b_i, 4) == '0)) |-> product_o == '0)
    else $error("zero operand"); // R8

  AST_NEG_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && valid_o && $past(signed_i, 4) && $past(a_i, 4) != '0 && $past(b_i, 4) != '0 &&
     ($past(a_i[W-1], 4) != $past(b_i[W-1], 4))) |-> product_o[2*W-1])
    else $error("sign of product"); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && product_o == '0)) else $error("reset state"); // R6

endmodule

bind booth_mul_pipe booth_mul_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
  .signed_i(signed_i), .valid_o(valid_o), .product_o(product_o)
);

// File: tb/sim_booth_mul_pipe.sv
`timescale 1ns/1ps
module sim_booth_mul_pipe;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] a_i, b_i;
  logic        signed_i;
  logic        valid_o;
  logic [63:0] product_o;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 1'b0;

  always #2 clk = ~clk;

  booth_mul_pipe #(.W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .signed_i(signed_i), .valid_o(valid_o), .product_o(product_o)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        s;
    logic [63:0] p;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b1, 64'h0000_0000_0000_0000, 4'd8},  // R8
    '{32'h1234_5678, 32'h0000_0000, 1'b0, 64'h0000_0000_0000_0000, 4'd8},  // R8
    '{32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd10}, // R10
    '{32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 64'h0000_0000_FFFF_FFFF, 4'd2},  // R2
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 64'h0000_0000_0000_0001, 4'd9},  // R9
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 64'hFFFF_FFFE_0000_0001, 4'd9},  // R9
    '{32'h8000_0000, 32'h8000_0000, 1'b1, 64'h4000_0000_0000_0000, 4'd7},  // R7
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 64'h4000_0000_0000_0000, 4'd7},  // R7
    '{32'h8000_0000, 32'h0000_0001, 1'b1, 64'hFFFF_FFFF_8000_0000, 4'd7},  // R7
    '{32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 64'h0000_0000_8000_0000, 4'd7},  // R7
    '{32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 64'h3FFF_FFFF_0000_0001, 4'd1},  // R1
    '{32'h0000_0003, 32'hFFFF_FFFD, 1'b1, 64'hFFFF_FFFF_FFFF_FFF7, 4'd10}, // R10
    '{32'h0001_0000, 32'h0001_0000, 1'b0, 64'h0000_0001_0000_0000, 4'd2},  // R2
    '{32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 64'h0000_0001_FFFF_FFFE, 4'd2}   // R2
  };

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic s);
    logic [63:0] ae, be;
    ae = s ? {{32{a[31]}}, a} : {32'd0, a};
    be = s ? {{32{b[31]}}, b} : {32'd0, b};
    return ae * be;
  endfunction

  task automatic rec(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard: four-edge delay line of expected results (R3, R4)
  logic [63:0] exp_cur;
  string       cur_tag;
  logic        sb_v [4];
  logic [63:0] sb_p [4];
  string       sb_t [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) sb_v[i] <= 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        sb_v[i] <= sb_v[i-1];
        sb_p[i] <= sb_p[i-1];
        sb_t[i] <= sb_t[i-1];
      end
      sb_v[0] <= valid_i;
      sb_p[0] <= exp_cur;
      sb_t[0] <= cur_tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      rec(valid_o === sb_v[3], "R4 valid_o", {63'd0, valid_o}, {63'd0, sb_v[3]});
      if (sb_v[3]) rec(product_o === sb_p[3], sb_t[3], product_o, sb_p[3]);
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic [63:0] e, input string t);
    @(negedge clk);
    a_i = a; b_i = b; signed_i = s; valid_i = 1'b1;
    exp_cur = e; cur_tag = t;
  endtask

  task automatic idle();
    @(negedge clk);
    a_i = $urandom; b_i = $urandom; signed_i = 1'($urandom);
    valid_i = 1'b0; exp_cur = '0; cur_tag = "R4";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    valid_i = 1'b0; a_i = '0; b_i = '0; signed_i = 1'b0;
    exp_cur = '0; cur_tag = "R4";
    repeat (3) @(negedge clk);
    // R6: reset state
    rec(valid_o === 1'b0, "R6 valid_o in reset", {63'd0, valid_o}, 64'd0);
    rec(product_o === 64'd0, "R6 product_o in reset", product_o, 64'd0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // table, back to back (R5)
    for (int i = 0; i < NV; i++)
      issue(TBL[i].a, TBL[i].b, TBL[i].s, TBL[i].p, $sformatf("R%0d table %0d", TBL[i].rq, i));
    idle();

    // R3: isolated op appears after exactly four edges
    repeat (6) idle();
    issue(32'h0000_0007, 32'hFFFF_FFF9, 1'b1, 64'hFFFF_FFFF_FFFF_FFCF, "R3 single");
    @(negedge clk);
    valid_i = 1'b0;
    rec(valid_o === 1'b0, "R3 edge1", {63'd0, valid_o}, 64'd0);
    @(negedge clk);
    rec(valid_o === 1'b0, "R3 edge2", {63'd0, valid_o}, 64'd0);
    @(negedge clk);
    rec(valid_o === 1'b0, "R3 edge3", {63'd0, valid_o}, 64'd0);
    @(negedge clk);
    rec(valid_o === 1'b1, "R3 edge4 valid", {63'd0, valid_o}, 64'd1);
    rec(product_o === 64'hFFFF_FFFF_FFFF_FFCF, "R3 edge4 product", product_o,
        64'hFFFF_FFFF_FFFF_FFCF);
    repeat (2) idle();

    // random back-to-back, both modes (R1, R2, R5)
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a, b;
      logic s;
      a = $urandom; b = $urandom; s = 1'($urandom);
      if (i % 17 == 0) a = 32'h8000_0000;
      if (i % 23 == 0) b = 32'hFFFF_FFFF;
      issue(a, b, s, ref_mul(a, b, s), s ? "R1 random" : "R2 random");
    end

    // random with idle gaps (R4, R5)
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic s;
      a = $urandom; b = $urandom; s = 1'($urandom);
      if ($urandom % 3 == 0) idle();
      else issue(a, b, s, ref_mul(a, b, s), "R5 gapped");
    end
    repeat (5) idle();

    // R6: reset during traffic clears at once and discards in-flight work
    for (int i = 0; i < 3; i++) begin
      logic [31:0] a, b;
      a = $urandom | 32'h1; b = $urandom | 32'h1;
      issue(a, b, 1'b0, ref_mul(a, b, 1'b0), "R5 pre-reset");
    end
    @(negedge clk);
    valid_i = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    rec(valid_o === 1'b0, "R6 async clear valid_o", {63'd0, valid_o}, 64'd0);
    rec(product_o === 64'd0, "R6 async clear product_o", product_o, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8) begin
      idle();
      rec(valid_o === 1'b0, "R6 flushed op must not appear", {63'd0, valid_o}, 64'd0);
    end

    chk_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule